// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit counting channel of a multi-channel interval timer. Software-side logic elsewhere decodes host accesses and hands this channel a load strobe, a 16-bit initial count and a 3-bit mode code. The channel then counts "ticks": system clock cycles on which the tick enable input is high. It drives a waveform output and a live count value that the interface block can latch. All logic runs on one system clock with a synchronous, active-high reset.

In the requirements below, N is the loaded period, where a count of 0 stands for 65536. d is the number of counted ticks since the most recent load or restart. A tick is counted on a cycle with `tick_en` high, no load and no restart. In modes 0 and 4 it also needs `gate_in` high. Both outputs are registered. The values seen after clock edge k+1 describe the channel state produced at edge k, so a load sampled at edge k first shows at the outputs after edge k+1.

The gate input is compared against its value on the previous cycle to find rising edges. The parameter `GATE_INIT` sets the assumed previous gate level coming out of reset. Instances for the first two channels use 1 and the third uses 0.

Top module: `ivc_channel`

## Requirements
- R1: A load sets N to `load_val`, or to 65536 when `load_val` is 0, and sets d to 0. On the second clock edge after the load strobe, `count_q` equals `load_val`.
- R2: Mode 0: `out_q` is 0 while d < N and 1 once d >= N, and it stays 1 until the next load. `count_q` = (N - d) mod 65536.
- R3: Mode 1: `out_q` is 1 while d < N and 0 afterwards. `count_q` = (N - d) mod 65536.
- R4: Mode 2: `out_q` is 1 exactly while d is a nonzero multiple of N. `count_q` = (N - (d mod N)) mod 65536.
- R5: Mode 3: `out_q` is 1 while (d mod N) < floor((N+1)/2). `count_q` = (N - ((2d) mod N)) mod 65536.
- R6: Modes 4 and 5: `out_q` is 1 only while d = N. `count_q` = (N - d) mod 65536.
- R7: In modes 1, 2, 3 and 5, a gate rising edge sets d to 0. A rising edge is `gate_in` at 1 on a cycle where it was 0 on the previous cycle. The gate level does not hold counting in these modes.
- R8: In modes 0 and 4, ticks count only while `gate_in` is 1, and a gate rising edge does not restart d.
- R9: Mode codes 6 and 7 on `mode_sel` select modes 2 and 3.
- R10: On a cycle with `tick_en` low and no load or restart, d does not change.
- R11: In one cycle a load takes priority over a gate restart, and a restart takes priority over a tick. The cycle that holds either one counts no tick.
- R12: After reset `out_q` and `count_q` are 0. The channel then behaves as mode 0 with N = 65536 and d = 0, with the previous gate level taken as `GATE_INIT`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter clock enable; one tick per high cycle |
| gate_in | input | 1 | Gate level |
| load_stb | input | 1 | Load the count and mode this cycle |
| load_val | input | CNT_W | Initial count, 0 meaning 65536 |
| mode_sel | input | 3 | Mode code captured with the load |
| out_q | output | 1 | Registered waveform output |
| count_q | output | CNT_W | Registered live count value |

## Verification
The assertions assume that the inputs are clean synchronous levels and that no load arrives during reset. The load-value property also assumes that reset stays low for the two cycles after a load. The stimulus drives every input at the falling clock edge, keeps reset asserted only at the start, and changes the mode only through a load. Random phases keep most periods short and gate toggles rare, so that restarts, wrap-around and terminal counts all occur often. Directed phases cover the 65536-tick zero count, the alias codes and same-cycle collisions.

// File: rtl/ivc_pkg.sv
`timescale 1ns/1ps
package ivc_pkg;
  localparam logic [2:0] MD_TERM   = 3'd0;
  localparam logic [2:0] MD_ONESHOT = 3'd1;
  localparam logic [2:0] MD_RATE   = 3'd2;
  localparam logic [2:0] MD_SQUARE = 3'd3;
  localparam logic [2:0] MD_SWSTB  = 3'd4;
  localparam logic [2:0] MD_HWSTB  = 3'd5;

  // codes above the last mode fold back onto the rate and square modes
  function automatic logic [2:0] fold_mode(input logic [2:0] code);
    return (code > MD_HWSTB) ? (code - 3'd4) : code;
  endfunction

  // modes where the gate level pauses counting
  function automatic logic gate_holds(input logic [2:0] md);
    return (md == MD_TERM) || (md == MD_SWSTB);
  endfunction

  // modes where a gate rising edge restarts the elapsed count
  function automatic logic gate_retrig(input logic [2:0] md);
    return (md == MD_ONESHOT) || (md == MD_RATE) ||
           (md == MD_SQUARE) || (md == MD_HWSTB);
  endfunction
endpackage

// File: rtl/ivc_cfg.sv
`timescale 1ns/1ps
module ivc_cfg #(
  parameter int CNT_W = 16,
  localparam int PER_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic [2:0]       mode_sel,
  output logic [PER_W-1:0] load_per,
  output logic [PER_W-1:0] period_q,
  output logic [2:0]       mode_q
);
  import ivc_pkg::*;

  localparam logic [PER_W-1:0] FULL_PER = {1'b1, {CNT_W{1'b0}}};

  // a zero count stands for the full range
  assign load_per = (load_val == '0) ? FULL_PER : {1'b0, load_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= FULL_PER;
      mode_q   <= MD_TERM;
    end else if (load_stb) begin
      period_q <= load_per;
      mode_q   <= fold_mode(mode_sel);
    end
  end
endmodule

// File: rtl/ivc_track.sv
`timescale 1ns/1ps
module ivc_track #(
  parameter int CNT_W = 16,
  localparam int PER_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic [PER_W-1:0] load_per,
  input  logic [PER_W-1:0] period_q,
  input  logic             restart,
  input  logic             step,
  output logic [CNT_W-1:0] vis_q,
  output logic [PER_W-1:0] rem_q,
  output logic             over_q,
  output logic [PER_W-1:0] ph_q,
  output logic             started_q
);
  localparam logic [PER_W-1:0] FULL_PER = {1'b1, {CNT_W{1'b0}}};

  logic ph_last;
  assign ph_last = (ph_q == (period_q - PER_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_q     <= '0;
      rem_q     <= FULL_PER;
      over_q    <= 1'b0;
      ph_q      <= '0;
      started_q <= 1'b0;
    end else if (load_stb) begin
      vis_q     <= load_val;
      rem_q     <= load_per;
      over_q    <= 1'b0;
      ph_q      <= '0;
      started_q <= 1'b0;
    end else if (restart) begin
      vis_q     <= CNT_W'(period_q);
      rem_q     <= period_q;
      over_q    <= 1'b0;
      ph_q      <= '0;
      started_q <= 1'b0;
    end else if (step) begin
      vis_q     <= vis_q - CNT_W'(1);
      started_q <= 1'b1;
      ph_q      <= ph_last ? '0 : (ph_q + PER_W'(1));
      if (rem_q == '0) begin
        over_q <= 1'b1;
      end else begin
        rem_q <= rem_q - PER_W'(1);
      end
    end
  end
endmodule

// File: rtl/ivc_outdec.sv
`timescale 1ns/1ps
module ivc_outdec #(
  parameter int CNT_W = 16,
  localparam int PER_W = CNT_W + 1
) (
  input  logic [2:0]       mode_q,
  input  logic [PER_W-1:0] period_q,
  input  logic [CNT_W-1:0] vis_q,
  input  logic [PER_W-1:0] rem_q,
  input  logic             over_q,
  input  logic [PER_W-1:0] ph_q,
  input  logic             started_q,
  output logic             out_d,
  output logic [CNT_W-1:0] cnt_d
);
  import ivc_pkg::*;

  logic [PER_W:0] per_x;
  logic [PER_W:0] half;
  logic [PER_W:0] dbl;
  logic [PER_W:0] twice_mod;

  always_comb begin
    per_x     = {1'b0, period_q};
    half      = (per_x + (PER_W + 1)'(1)) >> 1;
    dbl       = {ph_q, 1'b0};
    twice_mod = (dbl >= per_x) ? (dbl - per_x) : dbl;
  end

  always_comb begin
    out_d = 1'b0;
    cnt_d = vis_q;
    case (mode_q)
      MD_TERM: begin
        out_d = (rem_q == '0);
      end
      MD_ONESHOT: begin
        out_d = (rem_q != '0);
      end
      MD_RATE: begin
        out_d = (ph_q == '0) && started_q;
        cnt_d = CNT_W'(period_q - ph_q);
      end
      MD_SQUARE: begin
        out_d = ({1'b0, ph_q} < half);
        cnt_d = CNT_W'(per_x - twice_mod);
      end
      default: begin
        out_d = (rem_q == '0) && !over_q;
      end
    endcase
  end
endmodule

// File: rtl/ivc_channel.sv
`timescale 1ns/1ps
module ivc_channel #(
  parameter int CNT_W     = 16,
  parameter bit GATE_INIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             gate_in,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic [2:0]       mode_sel,
  output logic             out_q,
  output logic [CNT_W-1:0] count_q
);
  import ivc_pkg::*;

  localparam int PER_W = CNT_W + 1;

  logic             gate_prev;
  logic             gate_rise;
  logic             restart;
  logic             step;
  logic [PER_W-1:0] load_per;
  logic [PER_W-1:0] period_q;
  logic [2:0]       mode_q;
  logic [CNT_W-1:0] vis_q;
  logic [PER_W-1:0] rem_q;
  logic             over_q;
  logic [PER_W-1:0] ph_q;
  logic             started_q;
  logic             out_d;
  logic [CNT_W-1:0] cnt_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_prev <= GATE_INIT;
    end else begin
      gate_prev <= gate_in;
    end
  end

  assign gate_rise = gate_in && !gate_prev;
  assign restart   = gate_rise && gate_retrig(mode_q) && !load_stb;
  assign step      = tick_en && !load_stb && !restart &&
                     (!gate_holds(mode_q) || gate_in);

  ivc_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .load_stb (load_stb),
    .load_val (load_val),
    .mode_sel (mode_sel),
    .load_per (load_per),
    .period_q (period_q),
    .mode_q   (mode_q)
  );

  ivc_track #(.CNT_W(CNT_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .load_stb  (load_stb),
    .load_val  (load_val),
    .load_per  (load_per),
    .period_q  (period_q),
    .restart   (restart),
    .step      (step),
    .vis_q     (vis_q),
    .rem_q     (rem_q),
    .over_q    (over_q),
    .ph_q      (ph_q),
    .started_q (started_q)
  );

  ivc_outdec #(.CNT_W(CNT_W)) u_dec (
    .mode_q    (mode_q),
    .period_q  (period_q),
    .vis_q     (vis_q),
    .rem_q     (rem_q),
    .over_q    (over_q),
    .ph_q      (ph_q),
    .started_q (started_q),
    .out_d     (out_d),
    .cnt_d     (cnt_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= 1'b0;
      count_q <= '0;
    end else begin
      out_q   <= out_d;
      count_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ivc_channel_chk.sv
`timescale 1ns/1ps
module ivc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             gate_in,
  input logic             load_stb,
  input logic [CNT_W-1:0] load_val,
  input logic [2:0]       mode_sel,
  input logic             out_q,
  input logic [CNT_W-1:0] count_q,
  input logic [2:0]       mode_q,
  input logic             gate_rise
);
  // R1
  load_value_shown_chk: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> ##2 (count_q == $past(load_val, 2)));

  // R3
  oneshot_starts_high_chk: assert property (@(posedge clk) disable iff (rst)
    (load_stb && mode_sel == 3'd1) |-> ##2 out_q);

  // R2
  term_out_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 3'd0 && out_q && !$past(load_stb)) |=> out_q);

  // R6
  strobe_one_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == 3'd4 || mode_q == 3'd5) && out_q &&
     $past(tick_en && gate_in && !load_stb)) |=> !out_q);

  // R10
  idle_count_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !load_stb && !gate_rise) |=> ##1 $stable(count_q));
endmodule

bind ivc_channel ivc_channel_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_ivc_channel.sv
`timescale 1ns/1ps
module sim_ivc_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        gate_in = 1'b1;
  logic        load_stb = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode_sel = '0;
  logic        out_q;
  logic [15:0] count_q;

  always #2.5 clk = ~clk;

  ivc_channel #(.CNT_W(16), .GATE_INIT(1'b1)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .gate_in(gate_in),
    .load_stb(load_stb), .load_val(load_val), .mode_sel(mode_sel),
    .out_q(out_q), .count_q(count_q)
  );

  int    m_n = 65536;
  int    m_md = 0;
  int    m_d = 0;
  bit    m_gp = 1'b1;
  bit    e_out = 1'b0;
  int    e_cnt = 0;
  string e_tag = "R12";
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;

  function automatic bit mout(int md, int n, int d);
    case (md)
      0: return d >= n;
      1: return d < n;
      2: return ((d % n) == 0) && (d != 0);
      3: return (d % n) < ((n + 1) / 2);
      default: return d == n;
    endcase
  endfunction

  function automatic int mcnt(int md, int n, int d);
    case (md)
      2: return (n - (d % n)) & 16'hFFFF;
      3: return (n - ((2 * d) % n)) & 16'hFFFF;
      default: return (n - d) & 16'hFFFF;
    endcase
  endfunction

  function automatic string mtag(int md);
    case (md)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_now();
    checks += 2;
    if (out_q !== e_out) begin
      fails++;
      $display("FAIL %s out_q: got %0b expected %0b", e_tag, out_q, e_out);
    end
    if (count_q !== e_cnt[15:0]) begin
      fails++;
      $display("FAIL %s count_q: got %0d expected %0d", e_tag, count_q, e_cnt);
    end
  endtask

  task automatic step(input bit ld, input int lv, input int ms, input bit g,
                      input bit te, input string tag);
    bit rise;
    int nm;
    @(negedge clk);
    check_now();
    load_stb = ld; load_val = lv[15:0]; mode_sel = ms[2:0];
    gate_in = g; tick_en = te;
    e_out = mout(m_md, m_n, m_d);
    e_cnt = mcnt(m_md, m_n, m_d);
    e_tag = (tag == "") ? mtag(m_md) : tag;
    rise = g && !m_gp;
    m_gp = g;
    nm = (ms > 5) ? ms - 4 : ms;
    if (ld) begin
      m_n = (lv[15:0] == 0) ? 65536 : int'(lv[15:0]);
      m_md = nm;
      m_d = 0;
    end else if (rise && (m_md == 1 || m_md == 2 || m_md == 3 || m_md == 5)) begin
      m_d = 0;
    end else if (te && (!(m_md == 0 || m_md == 4) || g)) begin
      m_d++;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R12 watchdog: got no completion expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit g_cur;
    int unsigned seed_val;
    seed_val = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12: reset state, idle cycles
    step(0, 0, 0, 1, 0, "R12");
    step(0, 0, 0, 1, 0, "R12");

    // R1 with R2: zero count means 65536 ticks in mode 0
    step(1, 0, 0, 1, 1, "R1");
    for (int i = 0; i < 65540; i++) step(0, 0, 0, 1, 1, "R1");

    // R9: alias codes
    step(1, 4, 6, 1, 1, "R9");
    for (int i = 0; i < 12; i++) step(0, 0, 0, 1, 1, "R9");
    step(1, 5, 7, 1, 1, "R9");
    for (int i = 0; i < 14; i++) step(0, 0, 0, 1, 1, "R9");

    // R8: gate level pauses mode 0, rising edge does not restart mode 4
    step(1, 6, 0, 1, 1, "R8");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, "R8");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, "R8");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 1, "R8");
    step(1, 8, 4, 1, 1, "R8");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, "R8");
    step(0, 0, 0, 0, 1, "R8");
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 1, "R8");

    // R7: rising edge restarts modes 1 and 3, gate level ignored
    step(1, 5, 1, 1, 1, "R7");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, "R7");
    for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 1, "R7");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 1, "R7");
    step(1, 7, 3, 1, 1, "R7");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 1, "R7");
    step(0, 0, 0, 0, 1, "R7");
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 1, "R7");

    // R10: no ticks leaves the state unchanged
    step(1, 9, 2, 1, 1, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 1, "R10");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 1, "R10");

    // R11: load collides with a gate rise and a tick
    step(0, 0, 0, 0, 1, "R11");
    step(1, 3, 5, 1, 1, "R11");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, "R11");
    step(0, 0, 0, 0, 1, "R11");
    step(0, 0, 0, 1, 1, "R11");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 1, "R11");

    // constrained random across all modes
    g_cur = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      bit ld;
      int lv;
      int sel;
      ld = ($urandom % 40) == 0;
      sel = $urandom % 10;
      if (sel < 7)      lv = 1 + ($urandom % 12);
      else if (sel < 9) lv = 13 + ($urandom % 290);
      else              lv = ($urandom % 2 == 0) ? 0 : int'($urandom % 65536);
      if (($urandom % 15) == 0) g_cur = !g_cur;
      step(ld, lv, int'($urandom % 8), g_cur, ($urandom % 5) != 0, "");
    end

    @(negedge clk);
    check_now();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule